// File: doc/BRIEF.md
# Active Area Meter

This block measures how far the visible picture sits from the sync pulses of an incoming video stream. For every pixel-rate RGB sample it knows the pixel position within the line and the line position within the frame. It records where picture content first appears and where it last appears. Software or a higher controller arms a measurement with a one-cycle strobe. The measurement begins at the next frame boundary and runs over a programmed number of frames. When it ends, the block publishes four numbers and raises a one-cycle completion pulse: the leftmost and topmost start-of-picture positions, and the rightmost and bottommost end-of-picture positions.

A 2-bit function selector shares its control inputs with three other adjustment functions. Only the area measurement is implemented here. A strobe given under any other selector value is not acted on. A 2-bit sub-function input is accepted so that the interface stays uniform, but it does not change the area measurement. A pixel counts as picture content when any one of its red, green or blue components is strictly greater than the matching component of a threshold colour. One threshold colour is used for start detection and a second one for end detection.

Top module: `active_area_meter`

## Requirements
- R1: A start strobe arms the block only when `func_sel` is 2'b00. With 2'b01, 2'b10 or 2'b11 the strobe is ignored and `busy` stays low.
- R2: An accepted start strobe sets `busy` in the next cycle. Measurement begins at the first vsync rising edge after the strobe cycle, never at an edge in the strobe cycle itself.
- R3: The pixel position x is 0 in the cycle of an hsync rising edge and increases by one each cycle after it. The line position y is 0 in the cycle of a vsync rising edge, and this holds even when hsync rises in the same cycle. y increases by one at every later hsync rising edge.
- R4: A pixel qualifies as a start pixel when any component of `pix_rgb` is strictly greater than the same component of `thr_start`. Red is in bits [23:16], green in [15:8] and blue in [7:0]. `h_first` is the smallest x and `v_first` the smallest y of any start pixel, each minimum taken on its own axis across all measured frames.
- R5: End pixels use the same comparison against `thr_end`. `h_last` is the largest x and `v_last` the largest y of any end pixel across all measured frames.
- R6: A run covers `frame_count` frames, and a value of 0 counts as 1. In the cycle after the vsync rising edge that closes the last frame, `done` is high for exactly one cycle, `busy` is low, and the results are updated. The results then hold until the next `done`.
- R7: If no start pixel was seen, `h_first` and `v_first` read all ones. If no end pixel was seen, `h_last` and `v_last` read 0.
- R8: A start strobe while a measurement is running discards it. A new run then begins at the next vsync rising edge, and only frames from that point on contribute.
- R9: A start strobe in the same cycle as the vsync rising edge that closes the last frame wins over completion. No `done` is produced, `busy` stays high, and a fresh run begins at the following frame boundary.
- R10: `sub_sel` has no effect on the results.
- R11: After reset `busy` and `done` are low, `h_first` and `v_first` are all ones, and `h_last` and `v_last` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_rgb | input | 3*CW | Current pixel sample, red in the top byte |
| hsync | input | 1 | Horizontal sync, active high |
| vsync | input | 1 | Vertical sync, active high |
| func_sel | input | 2 | Function selector, 2'b00 is area measurement |
| sub_sel | input | 2 | Sub-function selector, no effect in this function |
| thr_start | input | 3*CW | Threshold colour for start-of-picture detection |
| thr_end | input | 3*CW | Threshold colour for end-of-picture detection |
| frame_count | input | FW | Number of frames per run, 0 means 1 |
| start | input | 1 | One-cycle arm strobe |
| h_first | output | XW | Leftmost start-pixel position |
| v_first | output | YW | Topmost start-pixel line |
| h_last | output | XW | Rightmost end-pixel position |
| v_last | output | YW | Bottommost end-pixel line |
| busy | output | 1 | Armed or measuring |
| done | output | 1 | One-cycle completion pulse |

## Verification
The arm strobe and the frame boundary that closes the last measured frame can land in the same cycle. The bench provokes this by issuing the strobe in the exact cycle in which vsync rises at the end of a one-frame run. It then requires that no completion pulse appears and that `busy` stays high. When the following run completes, the bench requires that the published results reflect only the frame after the restart. Because the picture rectangle shifts on alternate frames, a result taken from the wrong frame is visible in the numbers.

// File: rtl/aam_pkg.sv
package aam_pkg;
  typedef enum logic [1:0] {
    FN_AREA   = 2'b00,
    FN_BRIGHT = 2'b01,
    FN_PIXEL  = 2'b10,
    FN_PHASE  = 2'b11
  } fn_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_ARMED = 2'b01,
    ST_RUN   = 2'b10
  } ctrl_st_e;
endpackage

// File: rtl/aam_any_above.sv
module aam_any_above #(
  parameter int CW = 8,
  parameter int NC = 3
) (
  input  logic [NC*CW-1:0] pix,
  input  logic [NC*CW-1:0] thr,
  output logic             hit
);
  logic [NC-1:0] gt;

  generate
    for (genvar i = 0; i < NC; i++) begin : g_comp
      assign gt[i] = pix[i*CW +: CW] > thr[i*CW +: CW];
    end
  endgenerate

  assign hit = |gt;
endmodule

// File: rtl/aam_ctrl.sv
module aam_ctrl
  import aam_pkg::*;
#(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    func_sel,
  input  logic [FW-1:0] frame_count,
  input  logic          vs_rise,
  output logic          track_clr,
  output logic          track_en,
  output logic          publish,
  output logic          busy,
  output logic          done
);
  ctrl_st_e      state_q, state_d;
  logic [FW-1:0] left_q;
  logic          arm_req, last_edge;

  assign arm_req   = start && (func_sel == FN_AREA);
  assign last_edge = (state_q == ST_RUN) && vs_rise && (left_q == FW'(1));

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (arm_req) state_d = ST_ARMED;
      ST_ARMED: if (!arm_req && vs_rise) state_d = ST_RUN;
      ST_RUN: begin
        if (arm_req)        state_d = ST_ARMED;
        else if (last_edge) state_d = ST_IDLE;
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  assign track_clr = (state_q == ST_ARMED) && vs_rise && !arm_req;
  assign track_en  = track_clr || ((state_q == ST_RUN) && !arm_req && !last_edge);
  assign publish   = last_edge && !arm_req;
  assign busy      = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= publish;
      if (track_clr)
        left_q <= (frame_count == '0) ? FW'(1) : frame_count;
      else if ((state_q == ST_RUN) && vs_rise && !arm_req)
        left_q <= left_q - 1'b1;
    end
  end

  assert_ignore_mode_R1: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && start && func_sel != FN_AREA) |=> (state_q == ST_IDLE));

  assert_arm_wait_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && arm_req) |=> (state_q == ST_ARMED));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_run_count_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN) |-> (left_q != '0));

  assert_collide_R9: assert property (@(posedge clk) disable iff (rst)
    (last_edge && arm_req) |=> (state_q == ST_ARMED && !done));
endmodule

// File: rtl/aam_extent.sv
module aam_extent #(
  parameter int W        = 12,
  parameter bit KEEP_MAX = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic         hit,
  input  logic [W-1:0] pos,
  output logic [W-1:0] ext
);
  localparam logic [W-1:0] INIT = KEEP_MAX ? '0 : '1;

  logic better;

  generate
    if (KEEP_MAX) begin : g_max
      assign better = pos > ext;
      assert_grow_R5: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (ext >= $past(ext)));
    end else begin : g_min
      assign better = pos < ext;
      assert_shrink_R4: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (ext <= $past(ext)));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                    ext <= INIT;
    else if (clr)               ext <= hit ? pos : INIT;
    else if (en && hit && better) ext <= pos;
  end
endmodule

// File: rtl/active_area_meter.sv
module active_area_meter
  import aam_pkg::*;
#(
  parameter int CW = 8,
  parameter int XW = 12,
  parameter int YW = 12,
  parameter int FW = 4
) (
  input  logic [0:0]      clk,
  input  logic            rst,
  input  logic [3*CW-1:0] pix_rgb,
  input  logic            hsync,
  input  logic            vsync,
  input  logic [1:0]      func_sel,
  input  logic [1:0]      sub_sel,
  input  logic [3*CW-1:0] thr_start,
  input  logic [3*CW-1:0] thr_end,
  input  logic [FW-1:0]   frame_count,
  input  logic            start,
  output logic [XW-1:0]   h_first,
  output logic [YW-1:0]   v_first,
  output logic [XW-1:0]   h_last,
  output logic [YW-1:0]   v_last,
  output logic            busy,
  output logic            done
);
  localparam int NC = 3;

  logic          hs_d, vs_d, hs_rise, vs_rise;
  logic [XW-1:0] x_q, cur_x;
  logic [YW-1:0] y_q, cur_y, y_inc;
  logic          hit_start, hit_end;
  logic          track_clr, track_en, publish;
  logic [XW-1:0] xmin, xmax;
  logic [YW-1:0] ymin, ymax;
  logic          sub_unused;

  assign sub_unused = ^sub_sel;

  assign hs_rise = hsync & ~hs_d;
  assign vs_rise = vsync & ~vs_d;
  assign cur_x   = hs_rise ? '0 : x_q;
  assign y_inc   = (y_q == '1) ? y_q : y_q + 1'b1;
  assign cur_y   = vs_rise ? '0 : (hs_rise ? y_inc : y_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_d <= 1'b0;
      vs_d <= 1'b0;
      x_q  <= '0;
      y_q  <= '0;
    end else begin
      hs_d <= hsync;
      vs_d <= vsync;
      x_q  <= (cur_x == '1) ? cur_x : cur_x + 1'b1;
      y_q  <= cur_y;
    end
  end

  aam_any_above #(.CW(CW), .NC(NC)) cmp_start_i (
    .pix(pix_rgb), .thr(thr_start), .hit(hit_start));

  aam_any_above #(.CW(CW), .NC(NC)) cmp_end_i (
    .pix(pix_rgb), .thr(thr_end), .hit(hit_end));

  aam_ctrl #(.FW(FW)) ctrl_i (
    .clk(clk), .rst(rst), .start(start), .func_sel(func_sel),
    .frame_count(frame_count), .vs_rise(vs_rise),
    .track_clr(track_clr), .track_en(track_en), .publish(publish),
    .busy(busy), .done(done));

  aam_extent #(.W(XW), .KEEP_MAX(1'b0)) xmin_i (
    .clk(clk), .rst(rst), .clr(track_clr), .en(track_en),
    .hit(hit_start), .pos(cur_x), .ext(xmin));

  aam_extent #(.W(YW), .KEEP_MAX(1'b0)) ymin_i (
    .clk(clk), .rst(rst), .clr(track_clr), .en(track_en),
    .hit(hit_start), .pos(cur_y), .ext(ymin));

  aam_extent #(.W(XW), .KEEP_MAX(1'b1)) xmax_i (
    .clk(clk), .rst(rst), .clr(track_clr), .en(track_en),
    .hit(hit_end), .pos(cur_x), .ext(xmax));

  aam_extent #(.W(YW), .KEEP_MAX(1'b1)) ymax_i (
    .clk(clk), .rst(rst), .clr(track_clr), .en(track_en),
    .hit(hit_end), .pos(cur_y), .ext(ymax));

  always_ff @(posedge clk) begin
    if (rst) begin
      h_first <= '1;
      v_first <= '1;
      h_last  <= '0;
      v_last  <= '0;
    end else if (publish) begin
      h_first <= xmin;
      v_first <= ymin;
      h_last  <= xmax;
      v_last  <= ymax;
    end
  end

  assert_x_origin_R3: assert property (@(posedge clk) disable iff (rst)
    hs_rise |=> (x_q == XW'(1)));

  assert_y_origin_R3: assert property (@(posedge clk) disable iff (rst)
    vs_rise |=> (y_q == '0));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(h_first) && $stable(v_first) && $stable(h_last) && $stable(v_last)));
endmodule

// File: tb/active_area_meter_tb_top.sv
module active_area_meter_tb_top;
  localparam int LINE_LEN = 40;
  localparam int LINES    = 12;

  typedef struct packed {
    logic [3:0]  frames;
    logic [7:0]  x0;
    logic [7:0]  y0;
    logic [7:0]  x1;
    logic [7:0]  y1;
    logic [7:0]  sh;
    logic [23:0] col;
    logic [23:0] tlo;
    logic [23:0] thi;
    logic [1:0]  sub;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{4'd1, 8'd5, 8'd3, 8'd30, 8'd9, 8'd0, 24'h804020, 24'h202020, 24'h303030, 2'd0},
    '{4'd2, 8'd6, 8'd4, 8'd28, 8'd8, 8'd2, 24'h10FF10, 24'h404040, 24'h202020, 2'd2},
    '{4'd0, 8'd4, 8'd2, 8'd34, 8'd8, 8'd3, 24'h101011, 24'h101010, 24'h101011, 2'd1},
    '{4'd3, 8'd10, 8'd5, 8'd20, 8'd7, 8'd1, 24'h505050, 24'h606060, 24'h404040, 2'd3},
    '{4'd4, 8'd8, 8'd1, 8'd25, 8'd6, 8'd4, 24'h00FF00, 24'h20F020, 24'h10FE10, 2'd0}
  };

  localparam vec_t SHIFT1 =
    '{4'd1, 8'd6, 8'd4, 8'd28, 8'd8, 8'd2, 24'h804020, 24'h202020, 24'h303030, 2'd0};

  logic        clk = 1'b0;
  logic        rst;
  logic [23:0] pix_rgb;
  logic        hsync, vsync, start;
  logic [1:0]  func_sel, sub_sel;
  logic [23:0] thr_start, thr_end;
  logic [3:0]  frame_count;
  logic [11:0] h_first, v_first, h_last, v_last;
  logic        busy, done;

  int   n_cmp = 0;
  int   n_bad = 0;
  int   line = 0, col = 0, gf = 0, done_cnt = 0;
  vec_t cur;

  always #4 clk = ~clk;

  active_area_meter dut_i (
    .clk(clk), .rst(rst), .pix_rgb(pix_rgb), .hsync(hsync), .vsync(vsync),
    .func_sel(func_sel), .sub_sel(sub_sel), .thr_start(thr_start),
    .thr_end(thr_end), .frame_count(frame_count), .start(start),
    .h_first(h_first), .v_first(v_first), .h_last(h_last), .v_last(v_last),
    .busy(busy), .done(done));

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit any_above(input logic [23:0] c, input logic [23:0] t);
    for (int i = 0; i < 3; i++)
      if (c[i*8 +: 8] > t[i*8 +: 8]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic tick(input bit st);
    int p, x0, y0, x1, y1;
    @(negedge clk);
    p  = gf % 2;
    x0 = int'(cur.x0) + p * int'(cur.sh);
    y0 = int'(cur.y0) + p * int'(cur.sh);
    x1 = int'(cur.x1) + p * int'(cur.sh);
    y1 = int'(cur.y1) + p * int'(cur.sh);
    start   = st;
    hsync   = (col < 2);
    vsync   = (line < 2);
    pix_rgb = (col >= x0 && col <= x1 && line >= y0 && line <= y1) ? cur.col : 24'h101010;
    thr_start   = cur.tlo;
    thr_end     = cur.thi;
    frame_count = cur.frames;
    sub_sel     = cur.sub;
    @(posedge clk);
    #2;
    if (done) done_cnt++;
    col++;
    if (col == LINE_LEN) begin
      col = 0;
      line++;
      if (line == LINES) begin
        line = 0;
        gf++;
      end
    end
  endtask

  task automatic go_to(input int f, input int l, input int c);
    while (!(gf == f && line == l && col == c)) tick(1'b0);
  endtask

  task automatic expect_res(input vec_t v, input int af,
                            output int ehf, output int evf, output int ehl, output int evl);
    int n = (v.frames == 0) ? 1 : int'(v.frames);
    ehf = 'hFFF; evf = 'hFFF; ehl = 0; evl = 0;
    for (int k = 0; k < n; k++) begin
      int p = (af + k) % 2;
      int x0 = int'(v.x0) + p * int'(v.sh);
      int y0 = int'(v.y0) + p * int'(v.sh);
      int x1 = int'(v.x1) + p * int'(v.sh);
      int y1 = int'(v.y1) + p * int'(v.sh);
      if (any_above(v.col, v.tlo)) begin
        if (x0 < ehf) ehf = x0;
        if (y0 < evf) evf = y0;
      end
      if (any_above(v.col, v.thi)) begin
        if (x1 > ehl) ehl = x1;
        if (y1 > evl) evl = y1;
      end
    end
  endtask

  task automatic check_results(input string req, input vec_t v, input int af);
    int ehf, evf, ehl, evl;
    expect_res(v, af, ehf, evf, ehl, evl);
    check({req, " h_first"}, int'(h_first), ehf);
    check({req, " v_first"}, int'(v_first), evf);
    check({req, " h_last"},  int'(h_last),  ehl);
    check({req, " v_last"},  int'(v_last),  evl);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int af, af2, n;
    rst = 1'b1; start = 1'b0; hsync = 1'b0; vsync = 1'b0; pix_rgb = '0;
    func_sel = 2'b00; sub_sel = 2'b00; thr_start = '0; thr_end = '0; frame_count = '0;
    cur = VEC[0];
    repeat (5) @(posedge clk);
    #2;
    // R11 reset state
    check("R11 busy", int'(busy), 0);
    check("R11 done", int'(done), 0);
    check("R11 h_first", int'(h_first), 'hFFF);
    check("R11 v_first", int'(v_first), 'hFFF);
    check("R11 h_last", int'(h_last), 0);
    check("R11 v_last", int'(v_last), 0);
    @(negedge clk);
    rst = 1'b0;

    // R1: other selector values are ignored
    func_sel = 2'b01;
    go_to(gf + 1, 5, 10);
    tick(1'b1);
    check("R1 busy after strobe sel=01", int'(busy), 0);
    func_sel = 2'b11;
    tick(1'b1);
    done_cnt = 0;
    go_to(gf + 2, 0, 1);
    check("R1 busy over frames", int'(busy), 0);
    check("R1 no done", done_cnt, 0);
    func_sel = 2'b00;

    // table of vectors: R2 R3 R4 R5 R6 R7 R10
    for (int i = 0; i < 5; i++) begin
      cur = VEC[i];
      go_to(gf + 1, 5, 10);
      tick(1'b1);
      check("R2 busy after strobe", int'(busy), 1);
      af = gf + 1;
      n  = (cur.frames == 0) ? 1 : int'(cur.frames);
      done_cnt = 0;
      go_to(af + n, 0, 0);
      check("R6 no early done", done_cnt, 0);
      tick(1'b0);
      check("R6 done once", done_cnt, 1);
      check("R6 busy low", int'(busy), 0);
      check_results("R3 R4 R5 R7 R10", cur, af);
      tick(1'b0);
      check_results("R6 hold", cur, af);
    end

    // R8: restart while running
    cur = SHIFT1;
    go_to(gf + 1, 5, 10);
    tick(1'b1);
    af = gf + 1;
    go_to(af, 5, 10);
    tick(1'b1);
    af2 = af + 1;
    done_cnt = 0;
    go_to(af2 + 1, 0, 0);
    tick(1'b0);
    check("R8 done once", done_cnt, 1);
    check_results("R8", cur, af2);

    // R9: strobe on the closing frame boundary
    go_to(gf + 1, 5, 10);
    tick(1'b1);
    af = gf + 1;
    done_cnt = 0;
    go_to(af + 1, 0, 0);
    tick(1'b1);
    check("R9 no done", done_cnt, 0);
    check("R9 busy held", int'(busy), 1);
    af2 = af + 2;
    go_to(af2 + 1, 0, 0);
    tick(1'b0);
    check("R9 done once", done_cnt, 1);
    check_results("R9", cur, af2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule